// File: doc/BRIEF.md
# Transmit descriptor chain walker

This block walks the host-built linked list of transmit descriptors that carries one outgoing packet in a multi-channel packet DMA. A pending-queue entry gives the index of the first descriptor. The walker turns each index into a memory address. It holds a read request until the descriptor comes back, then pulls out the buffer byte count, the end-of-packet flag and the link to the next descriptor. For each descriptor it issues one buffer-transfer command to the downstream engine. It follows the links until it reaches the descriptor marked as the last of the packet.

Every descriptor is a fixed 16-byte slot in one contiguous table of up to 65,536 entries. The table's 32-bit base address is written as two 16-bit halves. A descriptor is returned to the host through a done-queue push only after the downstream engine acknowledges its transfer, so the done queue sees the chain in its original order. A descriptor whose byte count is zero is returned with an error flag, no transfer is issued for it, and the walk of that packet ends there.

The walker is a five-state machine. `IDLE` waits for a pending entry; the transition *accept* loads the first index. `FETCH` holds the read request; *good response* goes to `ISSUE`, *empty response* goes to `FAULT`. `ISSUE` holds the transfer command; *acknowledge* goes to `RETIRE`. `RETIRE` pushes a clean done entry; *link* returns to `FETCH` with the next index, *end of packet* returns to `IDLE`. `FAULT` pushes an error done entry; *abandon* returns to `IDLE`.

Top module: `txd_chain_walker`

## Requirements
- R1: `base_lo_wr` loads `base_wdata` into bits 15:0 of the descriptor base and `base_hi_wr` loads it into bits 31:16. Each write leaves the other half unchanged. Both halves reset to zero.
- R2: `cfg_err` is high exactly when any of base bits 3:0 is set. While it is high, `pend_ready` is low and no walk starts.
- R3: `pend_ready` is high only in `IDLE`. A pending entry is taken on a cycle where `pend_valid` and `pend_ready` are both high. While a walk is in progress, `pend_valid` has no effect.
- R4: For descriptor index i, `mem_addr` equals base + 16·i modulo 2^32. `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_rsp_valid` is high.
- R5: A response with a non-zero 13-bit `mem_rsp_count` produces one transfer command on the next cycle. The command carries `xfer_index` equal to the descriptor index, `xfer_count` equal to the byte count, and `xfer_last` equal to `mem_rsp_eop`. It is held unchanged until `xfer_ack` is high.
- R6: A response with `mem_rsp_count` = 0 issues no transfer command. On the next cycle it produces one done push with `done_err` = 1 and that descriptor's index. The walker then returns to `IDLE` without fetching the link.
- R7: A clean done push (`done_err` = 0) lasts one cycle. It occurs the cycle after `xfer_ack` is accepted and carries the acknowledged descriptor's index, so done entries follow chain order.
- R8: After a clean done push, if the descriptor's end-of-packet flag was 0, the next fetch uses `mem_rsp_next`. If the flag was 1, the walker returns to `IDLE` and the link field is ignored.
- R9: After reset, `mem_req`, `xfer_valid`, `done_push` and `cfg_err` are low and `pend_ready` is high.
- R10: `mem_rsp_valid` outside `FETCH` and `xfer_ack` outside `ISSUE` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_lo_wr | input | 1 | Write strobe for base address bits 15:0 |
| base_hi_wr | input | 1 | Write strobe for base address bits 31:16 |
| base_wdata | input | 16 | Data for a base-half write |
| cfg_err | output | 1 | Base address is not 16-byte aligned |
| pend_valid | input | 1 | Pending-queue entry present |
| pend_index | input | 16 | First descriptor index of the packet |
| pend_ready | output | 1 | Walker idle and able to take an entry |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor read data present |
| mem_rsp_count | input | 13 | Buffer byte count field |
| mem_rsp_eop | input | 1 | End-of-packet flag field |
| mem_rsp_next | input | 16 | Next-descriptor index field |
| xfer_valid | output | 1 | Buffer-transfer command present |
| xfer_index | output | 16 | Descriptor index of the command |
| xfer_count | output | 13 | Bytes to move |
| xfer_last | output | 1 | Final buffer of the packet |
| xfer_ack | input | 1 | Downstream engine has finished the buffer |
| done_push | output | 1 | Done-queue write strobe |
| done_index | output | 16 | Returned descriptor index |
| done_err | output | 1 | Descriptor returned because its count was zero |

## Verification
The hardest case to reach from the ports is an empty descriptor in the middle of a chain. The walker must have retired a good buffer, followed its link, and then given up without issuing a transfer or touching the dangling link. The bench reaches it by serving a two-descriptor chain whose second response carries a zero count and a live-looking link. It then watches that no further request appears. A misaligned base is the other awkward case, since a single half-write can make it appear. The bench programs only the low half with a stray bit and holds `pend_valid` high against the gate.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int TXD_ADDR_W    = 32;
    localparam int TXD_IDX_W     = 16;
    localparam int TXD_CNT_W     = 13;
    localparam int TXD_STRIDE_LG = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_RETIRE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/txd_base_reg.sv
module txd_base_reg #(
    parameter int ADDR_W   = 32,
    parameter int ALIGN_LG = 4,
    localparam int HALF_W  = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        half_wr,
    input  logic [HALF_W-1:0] wdata,
    output logic [ADDR_W-1:0] base,
    output logic              cfg_err
);

    logic [HALF_W-1:0] half_q [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (half_wr[h]) begin
                half_q[h] <= wdata;
            end
        end
    end

    assign base    = {half_q[1], half_q[0]};
    assign cfg_err = |base[ALIGN_LG-1:0];

    // R1: a low-half write leaves the high half alone
    p_lo_keeps_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (half_wr == 2'b01) |=> (base[ADDR_W-1:HALF_W] == $past(base[ADDR_W-1:HALF_W])));

    // R1: a high-half write leaves the low half alone
    p_hi_keeps_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (half_wr == 2'b10) |=> (base[HALF_W-1:0] == $past(base[HALF_W-1:0])));

endmodule

// File: rtl/txd_addr_gen.sv
module txd_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 16,
    parameter int STRIDE_LG = 4,
    localparam int PAD_W    = ADDR_W - IDX_W - STRIDE_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] addr_q;

    assign offset = {{PAD_W{1'b0}}, idx, {STRIDE_LG{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base + offset;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
    import txd_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_err,
    input  logic             pend_valid,
    input  logic [IDX_W-1:0] pend_index,
    output logic             pend_ready,
    output logic             load,
    output logic [IDX_W-1:0] load_idx,
    output logic             mem_req,
    input  logic             rsp_valid,
    input  logic [CNT_W-1:0] rsp_count,
    input  logic             rsp_eop,
    input  logic [IDX_W-1:0] rsp_next,
    output logic             xfer_valid,
    output logic [IDX_W-1:0] xfer_index,
    output logic [CNT_W-1:0] xfer_count,
    output logic             xfer_last,
    input  logic             xfer_ack,
    output logic             done_push,
    output logic [IDX_W-1:0] done_index,
    output logic             done_err
);

    walk_state_e      state_q, state_d;
    logic [IDX_W-1:0] cur_q, nxt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             eop_q;
    logic             accept, follow, captured;

    assign accept   = (state_q == ST_IDLE) && pend_valid && !cfg_err;
    assign follow   = (state_q == ST_RETIRE) && !eop_q;
    assign captured = (state_q == ST_FETCH) && rsp_valid;
    assign load     = accept || follow;
    assign load_idx = accept ? pend_index : nxt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_FETCH;
            ST_FETCH:  if (rsp_valid) state_d = (rsp_count == '0) ? ST_FAULT : ST_ISSUE;
            ST_ISSUE:  if (xfer_ack)  state_d = ST_RETIRE;
            ST_RETIRE: state_d = eop_q ? ST_IDLE : ST_FETCH;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            nxt_q <= '0;
            cnt_q <= '0;
            eop_q <= 1'b0;
        end else begin
            if (load) begin
                cur_q <= load_idx;
            end
            if (captured) begin
                cnt_q <= rsp_count;
                eop_q <= rsp_eop;
                nxt_q <= rsp_next;
            end
        end
    end

    always_comb begin
        pend_ready = 1'b0;
        mem_req    = 1'b0;
        xfer_valid = 1'b0;
        done_push  = 1'b0;
        done_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:   pend_ready = !cfg_err;
            ST_FETCH:  mem_req    = 1'b1;
            ST_ISSUE:  xfer_valid = 1'b1;
            ST_RETIRE: done_push  = 1'b1;
            ST_FAULT: begin
                done_push = 1'b1;
                done_err  = 1'b1;
            end
            default: ;
        endcase
    end

    assign xfer_index = cur_q;
    assign xfer_count = cnt_q;
    assign xfer_last  = eop_q;
    assign done_index = cur_q;

    // R3: request, command and done phases never overlap
    p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_ready, mem_req, xfer_valid, done_push}));

    // R6: an empty buffer never reaches the transfer interface
    p_no_empty_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_count != '0));

    // R6: an error return follows an empty response
    p_err_from_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_push && done_err) |-> $past(mem_req && rsp_valid && (rsp_count == '0)));

    // R7: a clean return follows an accepted acknowledge
    p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_push && !done_err) |-> $past(xfer_valid && xfer_ack));

    // R8: the last buffer of a packet sends the walker home
    p_eop_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_push && !done_err && eop_q) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/txd_chain_walker.sv
module txd_chain_walker
    import txd_pkg::*;
#(
    parameter int ADDR_W    = TXD_ADDR_W,
    parameter int IDX_W     = TXD_IDX_W,
    parameter int CNT_W     = TXD_CNT_W,
    parameter int STRIDE_LG = TXD_STRIDE_LG,
    localparam int HALF_W   = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_lo_wr,
    input  logic              base_hi_wr,
    input  logic [HALF_W-1:0] base_wdata,
    output logic              cfg_err,
    input  logic              pend_valid,
    input  logic [IDX_W-1:0]  pend_index,
    output logic              pend_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [CNT_W-1:0]  mem_rsp_count,
    input  logic              mem_rsp_eop,
    input  logic [IDX_W-1:0]  mem_rsp_next,
    output logic              xfer_valid,
    output logic [IDX_W-1:0]  xfer_index,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              xfer_last,
    input  logic              xfer_ack,
    output logic              done_push,
    output logic [IDX_W-1:0]  done_index,
    output logic              done_err
);

    logic [ADDR_W-1:0] base;
    logic              load;
    logic [IDX_W-1:0]  load_idx;

    txd_base_reg #(
        .ADDR_W   (ADDR_W),
        .ALIGN_LG (STRIDE_LG)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr ({base_hi_wr, base_lo_wr}),
        .wdata   (base_wdata),
        .base    (base),
        .cfg_err (cfg_err)
    );

    txd_addr_gen #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .STRIDE_LG (STRIDE_LG)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .idx   (load_idx),
        .base  (base),
        .addr  (mem_addr)
    );

    txd_walk_fsm #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_err    (cfg_err),
        .pend_valid (pend_valid),
        .pend_index (pend_index),
        .pend_ready (pend_ready),
        .load       (load),
        .load_idx   (load_idx),
        .mem_req    (mem_req),
        .rsp_valid  (mem_rsp_valid),
        .rsp_count  (mem_rsp_count),
        .rsp_eop    (mem_rsp_eop),
        .rsp_next   (mem_rsp_next),
        .xfer_valid (xfer_valid),
        .xfer_index (xfer_index),
        .xfer_count (xfer_count),
        .xfer_last  (xfer_last),
        .xfer_ack   (xfer_ack),
        .done_push  (done_push),
        .done_index (done_index),
        .done_err   (done_err)
    );

    // R2: a misaligned base blocks new walks
    p_misaligned_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pend_ready);

    // R4: request and address held until the response
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R5: transfer command held until acknowledged
    p_xfer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ack) |=>
            (xfer_valid && $stable(xfer_count) && $stable(xfer_index) && $stable(xfer_last)));

endmodule

// File: tb/tb_txd_chain_walker.sv
module tb_txd_chain_walker;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    localparam logic [31:0] V_BASE [NV] = '{32'h0000_0000, 32'h8000_0010, 32'h1234_5670,
                                           32'hFFFF_FFF0, 32'hFFFF_0000, 32'hA5A5_A5A0};
    localparam logic [15:0] V_IDX  [NV] = '{16'h0000, 16'h0001, 16'hFFFF,
                                           16'h0002, 16'hFFFF, 16'h8000};
    localparam logic [12:0] V_CNT  [NV] = '{13'd1, 13'd8191, 13'd64, 13'd300, 13'd4095, 13'd2};
    localparam int          V_LAT  [NV] = '{0, 2, 1, 3, 0, 5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_lo_wr = 1'b0, base_hi_wr = 1'b0;
    logic [15:0] base_wdata = '0;
    logic        cfg_err;
    logic        pend_valid = 1'b0;
    logic [15:0] pend_index = '0;
    logic        pend_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [12:0] mem_rsp_count = '0;
    logic        mem_rsp_eop = 1'b0;
    logic [15:0] mem_rsp_next = '0;
    logic        xfer_valid;
    logic [15:0] xfer_index;
    logic [12:0] xfer_count;
    logic        xfer_last;
    logic        xfer_ack = 1'b0;
    logic        done_push;
    logic [15:0] done_index;
    logic        done_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txd_chain_walker dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_lo_wr = 1'b1; base_wdata = b[15:0];
        @(negedge clk);
        base_lo_wr = 1'b0; base_hi_wr = 1'b1; base_wdata = b[31:16];
        @(negedge clk);
        base_hi_wr = 1'b0; base_wdata = 16'h0;
    endtask

    task automatic push(input logic [15:0] idx);
        @(negedge clk);
        chk("R3 ready before accept", {31'h0, pend_ready}, 32'h1);
        pend_valid = 1'b1; pend_index = idx;
        @(negedge clk);
        pend_valid = 1'b0; pend_index = 16'h0;
        chk("R3 ready drops while walking", {31'h0, pend_ready}, 32'h0);
    endtask

    task automatic serve(input logic [15:0] idx, input logic [31:0] exp_addr,
                         input logic [12:0] cnt, input bit eop,
                         input logic [15:0] nxt, input int lat);
        for (int w = 0; w < 40 && mem_req !== 1'b1; w++) @(negedge clk);
        chk("R4 request raised", {31'h0, mem_req}, 32'h1);
        chk("R4 descriptor address", mem_addr, exp_addr);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R4 request held", {31'h0, mem_req}, 32'h1);
            chk("R4 address held", mem_addr, exp_addr);
        end
        mem_rsp_valid = 1'b1; mem_rsp_count = cnt; mem_rsp_eop = eop; mem_rsp_next = nxt;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_count = 13'h1ABC; mem_rsp_eop = 1'b1; mem_rsp_next = 16'hDEAD;
        if (cnt == 13'd0) begin
            chk("R6 no command for empty buffer", {31'h0, xfer_valid}, 32'h0);
            chk("R6 error push", {30'h0, done_push, done_err}, 32'h3);
            chk("R6 error index", {16'h0, done_index}, {16'h0, idx});
            @(negedge clk);
        end else begin
            chk("R5 command valid", {31'h0, xfer_valid}, 32'h1);
            chk("R5 command index", {16'h0, xfer_index}, {16'h0, idx});
            chk("R5 command count", {19'h0, xfer_count}, {19'h0, cnt});
            chk("R5 command last", {31'h0, xfer_last}, {31'h0, eop});
            @(negedge clk);
            chk("R5 command held", {31'h0, xfer_valid}, 32'h1);
            chk("R7 no push before ack", {31'h0, done_push}, 32'h0);
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
            chk("R7 clean push", {30'h0, done_push, done_err}, 32'h2);
            chk("R7 pushed index", {16'h0, done_index}, {16'h0, idx});
            @(negedge clk);
            chk("R7 push lasts one cycle", {31'h0, done_push}, 32'h0);
        end
    endtask

    task automatic check_quiet(input string req, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            chk(req, {29'h0, mem_req, xfer_valid, done_push}, 32'h0);
        end
        chk(req, {31'h0, pend_ready}, 32'h1);
    endtask

    function automatic logic [31:0] desc_addr(input logic [31:0] b, input logic [15:0] i);
        return b + {12'h0, i, 4'h0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {28'h0, mem_req, xfer_valid, done_push, cfg_err}, 32'h0);
        chk("R9 reset ready", {31'h0, pend_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {28'h0, mem_req, xfer_valid, done_push, pend_ready}, 32'h1);

        // Table of single-buffer packets: base, index, count, response latency
        for (int v = 0; v < NV; v++) begin
            set_base(V_BASE[v]);
            chk("R1 aligned base no error", {31'h0, cfg_err}, 32'h0);
            push(V_IDX[v]);
            serve(V_IDX[v], desc_addr(V_BASE[v], V_IDX[v]), V_CNT[v], 1'b1,
                  16'h1234 + 16'(v), V_LAT[v]);
            check_quiet("R8 last buffer ends walk", 2);
        end

        // Three-buffer chain, pending input pressed during the walk
        set_base(32'h1000_0000);
        push(16'h0007);
        pend_valid = 1'b1; pend_index = 16'hBEEF;
        serve(16'h0007, desc_addr(32'h1000_0000, 16'h0007), 13'd100, 1'b0, 16'h0003, 1);
        chk("R3 busy ignores pending", {31'h0, pend_ready}, 32'h0);
        serve(16'h0003, desc_addr(32'h1000_0000, 16'h0003), 13'd8191, 1'b0, 16'h0020, 0);
        pend_valid = 1'b0; pend_index = 16'h0;
        serve(16'h0020, desc_addr(32'h1000_0000, 16'h0020), 13'd1, 1'b1, 16'h5555, 2);
        check_quiet("R8 link ignored on last buffer", 3);

        // Empty single descriptor with a live-looking link
        push(16'h0100);
        serve(16'h0100, desc_addr(32'h1000_0000, 16'h0100), 13'd0, 1'b0, 16'h0009, 0);
        check_quiet("R6 walk abandoned", 3);

        // Empty descriptor in the middle of a chain
        push(16'h0040);
        serve(16'h0040, desc_addr(32'h1000_0000, 16'h0040), 13'd5, 1'b0, 16'h0041, 0);
        serve(16'h0041, desc_addr(32'h1000_0000, 16'h0041), 13'd0, 1'b0, 16'h0042, 1);
        check_quiet("R6 mid-chain empty abandons", 3);

        // Stray response and acknowledge while idle
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_count = 13'd9; xfer_ack = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0; xfer_ack = 1'b0;
        check_quiet("R10 stray inputs ignored", 2);

        // Misaligned base via a single low-half write
        @(negedge clk);
        base_lo_wr = 1'b1; base_wdata = 16'h0008;
        @(negedge clk);
        base_lo_wr = 1'b0;
        chk("R2 misaligned flagged", {31'h0, cfg_err}, 32'h1);
        chk("R2 ready gated", {31'h0, pend_ready}, 32'h0);
        pend_valid = 1'b1; pend_index = 16'h0001;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 no walk while misaligned", {31'h0, mem_req}, 32'h0);
        end
        pend_valid = 1'b0;
        @(negedge clk);
        base_lo_wr = 1'b1; base_wdata = 16'h0000;
        @(negedge clk);
        base_lo_wr = 1'b0;
        chk("R2 error clears", {31'h0, cfg_err}, 32'h0);
        // R1: high half kept from earlier write, low half now zero
        push(16'h0002);
        serve(16'h0002, 32'h1000_0020, 13'd12, 1'b1, 16'h0, 0);
        check_quiet("R1 halves independent", 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule